// File: doc/BRIEF.md
# Two-Channel Wiper Code Register with Two-Wire Serial Slave

This block is the digital side of a dual-channel digital potentiometer. It is a slave on a two-wire serial bus. It oversamples SCL and SDA with the system clock, finds START and STOP conditions, and matches a 7-bit device address. The top five bits of that address are fixed and the low two come from strap pins. The block holds one 8-bit wiper code per channel, one shutdown flag per channel, and two general-purpose logic outputs.

A write transfer has three bytes: the device address, a command byte and a data byte. The command byte selects the channel. It can also recentre that channel's wiper, set or clear its shutdown flag, and set the two logic outputs. The data byte then loads the selected channel's wiper code. A read transfer has no command byte. It returns the wiper code of the channel that the most recent command byte selected. An active-low shutdown pin forces both channels into shutdown.

Top module: `i2c_wiper_slave`

## Requirements
- R1: After reset, both wiper codes are 8'h80, both shutdown outputs are 0, both logic outputs are 0 and SDA is released.
- R2: The slave acknowledges (pulls SDA low in the ninth clock) only an address byte whose bits 7..1 equal {5'b01011, addr_sel_i}. A transfer to any other address gets no acknowledge and changes no output.
- R3: In a write, the second byte is a command byte. Bit 7 selects the channel (0 = channel 1, 1 = channel 2), bit 4 goes to gpo_o[1] and bit 3 goes to gpo_o[0]. Bits 2..0 have no effect. The byte takes effect once it is acknowledged, even if no data byte follows.
- R4: Command bit 6 set to 1 loads 8'h80 into the selected channel's wiper code.
- R5: Command bit 5 writes the selected channel's shutdown flag (shut_o[0] = channel 1). While shdn_ni is low, both shut_o bits read 1.
- R6: The third byte of a write is acknowledged and loaded into the selected channel's wiper code. The other channel keeps its code.
- R7: A read (R/W bit 1) is acknowledged and shifts out the selected wiper code MSB first. A master NACK ends the transfer.
- R8: A STOP or repeated START at any point returns the slave to idle and releases SDA. A partly received byte updates nothing.
- R9: The slave changes its SDA drive only while SCL is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock used to oversample the bus |
| rst_ni | input | 1 | Asynchronous reset, active low |
| scl_i | input | 1 | Serial clock from the bus |
| sda_i | input | 1 | Serial data as seen on the bus |
| sda_drive_o | output | 1 | 1 pulls SDA low (open drain) |
| addr_sel_i | input | 2 | Low two bits of the device address |
| shdn_ni | input | 1 | Forces both channels into shutdown when low |
| wiper_c1_o | output | 8 | Channel 1 wiper code |
| wiper_c2_o | output | 8 | Channel 2 wiper code |
| shut_o | output | 2 | Per-channel shutdown, bit 0 = channel 1 |
| gpo_o | output | 2 | General-purpose logic outputs from command bits 4 and 3 |

## Verification
Several functions can land in the same cycle. A single command byte can recentre the wiper, change the shutdown flag and update both logic outputs at the moment it is acknowledged. Separately, a cleared shutdown flag can meet a low shutdown pin. The bench sends a directed command byte with bits 6, 5, 4 and 3 all set, and checks the wiper, shutdown and logic outputs together against a bench model. It then drives shdn_ni low while that channel's flag is clear, and expects both shutdown outputs high. A STOP that arrives in the middle of a data byte, on a command that was already acknowledged, must leave the command's effect in place and discard the partial data.

// File: rtl/wiper_pkg.sv
package wiper_pkg;
  localparam int BYTE_W = 8;
  localparam int CNT_W  = 4;
  localparam logic [4:0] DEV_ID = 5'b01011;
  localparam logic [BYTE_W-1:0] MID_CODE = 8'h80;

  typedef enum logic [2:0] {S_IDLE, S_ADDR, S_INSTR, S_DATA, S_READ, S_SKIP} phase_e;

  typedef struct packed {
    logic chan;
    logic mid;
    logic off;
    logic o2;
    logic o1;
  } instr_t;
endpackage

// File: rtl/i2c_line_sampler.sv
module i2c_line_sampler #(
  parameter int SYNC_N = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic scl_i,
  input  logic sda_i,
  output logic sda_o,
  output logic scl_rise_o,
  output logic scl_fall_o,
  output logic start_o,
  output logic stop_o
);
  logic [SYNC_N-1:0] scl_s, sda_s;
  logic scl_p, sda_p, scl_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      scl_s <= '1;
      sda_s <= '1;
      scl_p <= 1'b1;
      sda_p <= 1'b1;
    end else begin
      scl_s <= {scl_s[SYNC_N-2:0], scl_i};
      sda_s <= {sda_s[SYNC_N-2:0], sda_i};
      scl_p <= scl_s[SYNC_N-1];
      sda_p <= sda_s[SYNC_N-1];
    end
  end

  assign scl_q      = scl_s[SYNC_N-1];
  assign sda_o      = sda_s[SYNC_N-1];
  assign scl_rise_o = scl_q & ~scl_p;
  assign scl_fall_o = ~scl_q & scl_p;
  assign start_o    = scl_q & scl_p & sda_p & ~sda_o;
  assign stop_o     = scl_q & scl_p & ~sda_p & sda_o;
endmodule

// File: rtl/i2c_frame_engine.sv
module i2c_frame_engine
  import wiper_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              scl_rise_i,
  input  logic              scl_fall_i,
  input  logic              start_i,
  input  logic              stop_i,
  input  logic              sda_i,
  input  logic [1:0]        dev_lo_i,
  input  logic [BYTE_W-1:0] rd_data_i,
  output logic              sda_drive_o,
  output logic              instr_we_o,
  output instr_t            instr_o,
  output logic              data_we_o,
  output logic [BYTE_W-1:0] data_o
);
  phase_e             phase;
  logic [CNT_W-1:0]   cnt;
  logic [BYTE_W-1:0]  sh, tx;
  logic               rw, nack, ack_ok;

  // cnt: 0..7 bits, 8 byte done, 9 ack driven, 10 ack clock seen
  assign ack_ok  = (phase != S_ADDR) || (sh[7:1] == {DEV_ID, dev_lo_i});
  assign data_o  = sh;
  assign instr_o = instr_t'(sh[7:3]);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      phase <= S_IDLE;
      cnt <= '0;
      sh <= '0;
      tx <= '0;
      rw <= 1'b0;
      nack <= 1'b0;
      sda_drive_o <= 1'b0;
      instr_we_o <= 1'b0;
      data_we_o <= 1'b0;
    end else begin
      instr_we_o <= 1'b0;
      data_we_o  <= 1'b0;
      if (start_i) begin
        phase <= S_ADDR;
        cnt <= '0;
        sda_drive_o <= 1'b0;
      end else if (stop_i) begin
        phase <= S_IDLE;
        cnt <= '0;
        sda_drive_o <= 1'b0;
      end else begin
        unique case (phase)
          S_ADDR, S_INSTR, S_DATA: begin
            if (scl_rise_i) begin
              if (cnt < CNT_W'(8)) begin
                sh  <= {sh[BYTE_W-2:0], sda_i};
                cnt <= cnt + 1'b1;
              end else if (cnt == CNT_W'(9)) begin
                cnt <= CNT_W'(10);
                if (phase == S_ADDR)  rw <= sh[0];
                if (phase == S_INSTR) instr_we_o <= 1'b1;
                if (phase == S_DATA)  data_we_o <= 1'b1;
              end
            end else if (scl_fall_i) begin
              if (cnt == CNT_W'(8)) begin
                if (ack_ok) begin
                  sda_drive_o <= 1'b1;
                  cnt <= CNT_W'(9);
                end else begin
                  phase <= S_SKIP;
                end
              end else if (cnt == CNT_W'(10)) begin
                cnt <= '0;
                if (phase == S_ADDR && rw) begin
                  phase <= S_READ;
                  tx <= rd_data_i;
                  sda_drive_o <= ~rd_data_i[7];
                end else begin
                  sda_drive_o <= 1'b0;
                  phase <= (phase == S_ADDR) ? S_INSTR :
                           (phase == S_INSTR) ? S_DATA : S_SKIP;
                end
              end
            end
          end
          S_READ: begin
            if (scl_rise_i) begin
              if (cnt < CNT_W'(8)) cnt <= cnt + 1'b1;
              else if (cnt == CNT_W'(9)) begin
                nack <= sda_i;
                cnt <= CNT_W'(10);
              end
            end else if (scl_fall_i) begin
              if (cnt != '0 && cnt < CNT_W'(8)) begin
                tx <= {tx[BYTE_W-2:0], 1'b0};
                sda_drive_o <= ~tx[6];
              end else if (cnt == CNT_W'(8)) begin
                sda_drive_o <= 1'b0;
                cnt <= CNT_W'(9);
              end else if (cnt == CNT_W'(10)) begin
                cnt <= '0;
                if (nack) phase <= S_SKIP;
                else begin
                  tx <= rd_data_i;
                  sda_drive_o <= ~rd_data_i[7];
                end
              end
            end
          end
          default: ;
        endcase
      end
    end
  end
endmodule

// File: rtl/wiper_reg_bank.sv
module wiper_reg_bank
  import wiper_pkg::*;
#(
  parameter int NUM_CH = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              instr_we_i,
  input  instr_t            instr_i,
  input  logic              data_we_i,
  input  logic [BYTE_W-1:0] data_i,
  input  logic              shdn_ni,
  output logic [BYTE_W-1:0] wiper_o [NUM_CH],
  output logic [NUM_CH-1:0] shut_o,
  output logic [1:0]        gpo_o,
  output logic [BYTE_W-1:0] rd_data_o
);
  localparam int SEL_W = $clog2(NUM_CH);

  logic [SEL_W-1:0]  sel;
  logic [NUM_CH-1:0] off_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sel   <= '0;
      gpo_o <= '0;
    end else if (instr_we_i) begin
      sel   <= SEL_W'(instr_i.chan);
      gpo_o <= {instr_i.o2, instr_i.o1};
    end
  end

  for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
    logic hit_instr, hit_data;
    assign hit_instr = instr_we_i && (SEL_W'(instr_i.chan) == SEL_W'(c));
    assign hit_data  = data_we_i && (sel == SEL_W'(c));

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        wiper_o[c] <= MID_CODE;
        off_q[c]   <= 1'b0;
      end else begin
        if (hit_instr) begin
          off_q[c] <= instr_i.off;
          if (instr_i.mid) wiper_o[c] <= MID_CODE;
        end
        if (hit_data) wiper_o[c] <= data_i;
      end
    end
    assign shut_o[c] = off_q[c] | ~shdn_ni;
  end

  assign rd_data_o = wiper_o[sel];
endmodule

// File: rtl/i2c_wiper_slave.sv
module i2c_wiper_slave
  import wiper_pkg::*;
#(
  parameter int SYNC_N = 2
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       scl_i,
  input  logic       sda_i,
  output logic       sda_drive_o,
  input  logic [1:0] addr_sel_i,
  input  logic       shdn_ni,
  output logic [7:0] wiper_c1_o,
  output logic [7:0] wiper_c2_o,
  output logic [1:0] shut_o,
  output logic [1:0] gpo_o
);
  localparam int NUM_CH = 2;

  logic sda_q, scl_rise, scl_fall, start_w, stop_w;
  logic instr_we, data_we;
  instr_t instr;
  logic [BYTE_W-1:0] data_w, rd_data;
  logic [BYTE_W-1:0] wiper [NUM_CH];

  i2c_line_sampler #(.SYNC_N(SYNC_N)) u_samp (
    .clk_i, .rst_ni, .scl_i, .sda_i,
    .sda_o(sda_q), .scl_rise_o(scl_rise), .scl_fall_o(scl_fall),
    .start_o(start_w), .stop_o(stop_w)
  );

  i2c_frame_engine u_eng (
    .clk_i, .rst_ni,
    .scl_rise_i(scl_rise), .scl_fall_i(scl_fall),
    .start_i(start_w), .stop_i(stop_w), .sda_i(sda_q),
    .dev_lo_i(addr_sel_i), .rd_data_i(rd_data),
    .sda_drive_o, .instr_we_o(instr_we), .instr_o(instr),
    .data_we_o(data_we), .data_o(data_w)
  );

  wiper_reg_bank #(.NUM_CH(NUM_CH)) u_bank (
    .clk_i, .rst_ni,
    .instr_we_i(instr_we), .instr_i(instr),
    .data_we_i(data_we), .data_i(data_w),
    .shdn_ni, .wiper_o(wiper), .shut_o, .gpo_o, .rd_data_o(rd_data)
  );

  assign wiper_c1_o = wiper[0];
  assign wiper_c2_o = wiper[1];
endmodule

// File: rtl/i2c_wiper_slave_chk.sv
module i2c_wiper_slave_chk (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       scl_i,
  input logic       shdn_ni,
  input logic       sda_drive_o,
  input logic       stop_seen,
  input logic [7:0] wiper_c1_o,
  input logic [7:0] wiper_c2_o,
  input logic [1:0] shut_o,
  input logic [1:0] gpo_o
);
  p_drive_stable_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (scl_i && $past(scl_i)) |-> $stable(sda_drive_o));

  p_shut_pin_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !shdn_ni |-> (shut_o == 2'b11));

  p_wiper_scl_high_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !($stable(wiper_c1_o) && $stable(wiper_c2_o)) |-> scl_i);

  p_gpo_scl_high_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(gpo_o) |-> scl_i);

  p_stop_release_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stop_seen |=> !sda_drive_o);
endmodule

bind i2c_wiper_slave i2c_wiper_slave_chk u_chk (
  .clk_i, .rst_ni, .scl_i, .shdn_ni, .sda_drive_o,
  .stop_seen(stop_w), .wiper_c1_o, .wiper_c2_o, .shut_o, .gpo_o
);

// File: tb/i2c_wiper_slave_bench.sv
module i2c_wiper_slave_bench;
  localparam int Q = 6;
  localparam logic [1:0] ASEL = 2'b10;

  logic clk = 0, rst_ni = 0;
  logic scl_m = 1, sda_m = 1, shdn_ni = 1;
  logic sda_drive;
  wire  sda_line = sda_m & ~sda_drive;
  logic [7:0] w1, w2;
  logic [1:0] shut, gpo;
  int errors = 0, checks = 0;
  logic [7:0] exp_w [2];
  logic [1:0] exp_sd, exp_gpo;
  logic exp_sel;
  bit done = 0;

  always #2 clk = ~clk;

  i2c_wiper_slave u_i2c_wiper_slave (
    .clk_i(clk), .rst_ni, .scl_i(scl_m), .sda_i(sda_line),
    .sda_drive_o(sda_drive), .addr_sel_i(ASEL), .shdn_ni,
    .wiper_c1_o(w1), .wiper_c2_o(w2), .shut_o(shut), .gpo_o(gpo)
  );

  task automatic tick(int n); repeat (n) @(negedge clk); endtask

  task automatic chk(bit ok, string tag, int act, int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic send_bit(logic b);
    sda_m = b; tick(Q); scl_m = 1; tick(2*Q); scl_m = 0; tick(Q);
  endtask
  task automatic recv_bit(output logic b);
    sda_m = 1; tick(Q); scl_m = 1; tick(Q); b = sda_line; tick(Q); scl_m = 0; tick(Q);
  endtask
  task automatic i2c_start();
    sda_m = 1; tick(Q); scl_m = 1; tick(Q); sda_m = 0; tick(Q); scl_m = 0; tick(Q);
  endtask
  task automatic i2c_stop();
    sda_m = 0; tick(Q); scl_m = 1; tick(Q); sda_m = 1; tick(2*Q);
  endtask
  task automatic send_byte(logic [7:0] b, output bit ack);
    logic a;
    for (int i = 7; i >= 0; i--) send_bit(b[i]);
    recv_bit(a);
    ack = !a;
  endtask
  task automatic read_byte(output logic [7:0] v);
    logic b;
    for (int i = 7; i >= 0; i--) begin recv_bit(b); v[i] = b; end
    send_bit(1'b1);
  endtask

  task automatic model_instr(logic [7:0] c);
    exp_sel = c[7];
    exp_gpo = {c[4], c[3]};
    exp_sd[c[7]] = c[5];
    if (c[6]) exp_w[c[7]] = 8'h80;
  endtask

  function automatic logic [1:0] exp_shut();
    return exp_sd | {2{~shdn_ni}};
  endfunction

  task automatic check_all(string tag);
    tick(4);
    chk(w1 == exp_w[0], {tag, " wiper c1"}, w1, exp_w[0]);
    chk(w2 == exp_w[1], {tag, " wiper c2"}, w2, exp_w[1]);
    chk(shut == exp_shut(), {tag, " shut"}, shut, exp_shut());
    chk(gpo == exp_gpo, {tag, " gpo"}, gpo, exp_gpo);
    chk(!sda_drive, {tag, " sda released"}, sda_drive, 0);
  endtask

  task automatic do_write(logic [7:0] c, logic [7:0] d, bit with_data, string tag);
    bit a;
    i2c_start();
    send_byte({5'b01011, ASEL, 1'b0}, a); chk(a, {tag, " R2 addr ack"}, a, 1);
    send_byte(c, a); chk(a, {tag, " R3 instr ack"}, a, 1);
    model_instr(c);
    if (with_data) begin
      send_byte(d, a); chk(a, {tag, " R6 data ack"}, a, 1);
      exp_w[exp_sel] = d;
    end
    i2c_stop();
    check_all(tag);
  endtask

  task automatic do_read(string tag);
    bit a; logic [7:0] v;
    i2c_start();
    send_byte({5'b01011, ASEL, 1'b1}, a); chk(a, {tag, " R7 addr ack"}, a, 1);
    read_byte(v);
    chk(v == exp_w[exp_sel], {tag, " R7 read data"}, v, exp_w[exp_sel]);
    i2c_stop();
    check_all(tag);
  endtask

  task automatic do_wrong_addr(string tag);
    bit a; logic [1:0] bad;
    bad = ASEL ^ 2'($urandom_range(1, 3));
    i2c_start();
    send_byte({5'b01011, bad, 1'b0}, a); chk(!a, {tag, " R2 no ack"}, a, 0);
    send_byte(8'hFF, a);
    send_byte(8'h12, a);
    i2c_stop();
    check_all(tag);
  endtask

  task automatic do_abort(logic [7:0] c, bit restart, string tag);
    bit a;
    i2c_start();
    send_byte({5'b01011, ASEL, 1'b0}, a);
    send_byte(c, a);
    model_instr(c);
    for (int i = 0; i < 4; i++) send_bit(1'($urandom_range(0, 1)));
    if (restart) begin
      i2c_start();
      send_byte({5'b01011, ASEL, 1'b1}, a);
      begin logic [7:0] v; read_byte(v);
        chk(v == exp_w[exp_sel], {tag, " R8 read after restart"}, v, exp_w[exp_sel]); end
    end
    i2c_stop();
    check_all(tag);
  endtask

  initial begin
    int unsigned seed;
    seed = $urandom(32'h5EED_1234);
    exp_w[0] = 8'h80; exp_w[1] = 8'h80; exp_sd = 0; exp_gpo = 0; exp_sel = 0;
    tick(3); rst_ni = 1; tick(3);
    check_all("R1 reset");
    // R3/R4/R5 together: bits 6,5,4,3 in one command on channel 2
    do_write(8'hFF, 8'h00, 0, "R4 R5 R3 combined");
    do_write(8'h27, 8'h00, 0, "R3 low bits ignored");
    do_write(8'h00, 8'h3C, 1, "R6 c1 load");
    do_write(8'h80, 8'hFF, 1, "R6 c2 max");
    do_write(8'h00, 8'h00, 1, "R6 c1 zero");
    do_read("R7 read c1");
    do_write(8'h80, 8'h00, 0, "R3 select c2");
    do_read("R7 read c2");
    shdn_ni = 0; tick(2);
    do_write(8'h00, 8'h00, 0, "R5 pin low clear flag");
    shdn_ni = 1; tick(2);
    check_all("R5 pin released");
    do_write(8'h40, 8'h00, 0, "R4 midscale c1");
    do_abort(8'h98, 0, "R8 stop mid data");
    do_abort(8'h08, 1, "R8 restart mid data");
    do_wrong_addr("R2 wrong address");
    for (int n = 0; n < 40; n++) begin
      case ($urandom_range(0, 4))
        0: do_write(8'($urandom), 8'($urandom), 1, "R6 rand write");
        1: do_write(8'($urandom), 8'h00, 0, "R3 rand instr");
        2: do_read("R7 rand read");
        3: do_wrong_addr("R2 rand wrong");
        default: do_abort(8'($urandom), 1'($urandom_range(0, 1)), "R8 rand abort");
      endcase
    end
    done = 1;
  end

  initial begin
    int cyc = 0;
    while (!done && cyc < 190000) begin @(posedge clk); cyc++; end
    if (!done) chk(0, "watchdog R1..", cyc, 0);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule